// File: doc/BRIEF.md
# Keypad Lock Unlock Sequencer

This block guards a locked keypad with a timed two-key unlock sequence. Software writes a lock request and the block goes locked. From then on, key-press events reach it as a valid strobe with a key code. Pressing the first unlock key opens a window, counted in seconds on an external one-second tick. Pressing the second unlock key inside that window unlocks the keypad and raises a one-cycle lock interrupt. Any other key, or the end of the window, sends the sequence back to waiting for the first unlock key.

An eight-bit timer configuration word holds two fields. Bits 2:0 are the unlock window in seconds, and a zero there means locking cannot be enabled. Bits 7:3 are an interrupt-mask period in seconds. When the mask period is non-zero, the first key press while locked raises a one-cycle key interrupt and starts the mask timer. Later presses stay silent until that timer runs out. When either timer expires, the sequence returns to its locked starting state and both timers are cleared.

Both fields are sampled when their timer is loaded. The states are OPEN (unlocked), ARMED (locked, waiting for unlock key 1) and WAIT2 (locked, waiting for unlock key 2). The transitions are:
- OPEN to ARMED on a lock request with a non-zero window.
- ARMED to WAIT2 on unlock key 1.
- WAIT2 to OPEN on unlock key 2.
- WAIT2 to ARMED on any other key or on window expiry.
- ARMED or WAIT2 to ARMED on mask expiry.

Top module: `keylock_seq`

## Requirements
- R1: After reset `locked`, `key_irq` and `lock_irq` are all 0, and an asynchronous reset taken while locked returns `locked` to 0.
- R2: A `lock_wr` pulse while unlocked sets `locked` after the next clock edge only if `tmr_cfg[2:0]` is non-zero; with `tmr_cfg[2:0]` equal to zero the pulse is ignored and `locked` stays 0.
- R3: While unlocked, key presses raise no interrupt. While locked, a `lock_wr` pulse is ignored and `locked` stays 1.
- R4: In WAIT2, a press of `unlock_key2` clears `locked` and raises `lock_irq` for exactly one cycle, both visible after the clock edge that samples the press.
- R5: The window timer loads `tmr_cfg[2:0]` at the unlock key 1 press. On the tick that brings it to zero, the sequence returns to ARMED, so a later `unlock_key2` press alone does not unlock.
- R6: In WAIT2, a press of any key other than `unlock_key2` returns the sequence to ARMED, and a following `unlock_key2` press does not unlock.
- R7: With `tmr_cfg[7:3]` non-zero, the first press while locked raises `key_irq` for one cycle after the sampling edge and loads the mask timer; further presses raise no `key_irq` while the mask timer is running.
- R8: The mask timer expires on the `tmr_cfg[7:3]`-th tick after its load. The sequence then returns to ARMED, and the next press raises `key_irq` again.
- R9: With `tmr_cfg[7:3]` equal to zero, no `key_irq` is raised while locked, and only the completed unlock raises an interrupt (`lock_irq`).
- R10: A key press in the same cycle as a timer expiry is dropped. Expiry wins, and the press neither advances the sequence nor raises `key_irq`.
- R11: Expiry of either timer clears both timers, so after a window expiry the next press raises `key_irq` again when the mask period is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cfg | input | 8 | Bits 2:0 unlock window (s), bits 7:3 interrupt-mask period (s) |
| unlock_key1 | input | 7 | Code of the first unlock key |
| unlock_key2 | input | 7 | Code of the second unlock key |
| lock_wr | input | 1 | One-cycle lock request |
| sec_tick | input | 1 | One-cycle pulse once per second |
| press_vld | input | 1 | A key press event is present this cycle |
| press_key | input | 7 | Code of the pressed key |
| key_irq | output | 1 | One-cycle key-event interrupt |
| lock_irq | output | 1 | One-cycle interrupt on completed unlock |
| locked | output | 1 | Keypad is locked |

## Verification
The bench builds the block with its default widths: a 7-bit key code, a 3-bit window field and a 5-bit mask field. It drives `sec_tick` directly with window values of 1 to 3 and mask values of 0, 1 and 3. With these small values, a window expiry, a mask expiry and an expiry coinciding with a press are all reachable within a few cycles, alongside the mask-disabled and window-zero cases.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_ARMED = 2'd1,
        ST_WAIT2 = 2'd2
    } kl_state_e;

endpackage

// File: rtl/kl_sec_timer.sv
module kl_sec_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         tick,
    output logic         running,
    output logic         expire
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign running = (cnt != '0);
    assign expire  = tick && (cnt == ONE);

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !clear) |=> $stable(cnt))
        else $error("timer count moved without tick");

    // R8
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !clear && cnt > ONE) |=> (cnt == $past(cnt) - ONE))
        else $error("timer did not step down by one");

endmodule

// File: rtl/kl_seq_fsm.sv
module kl_seq_fsm
    import keylock_pkg::*;
#(
    parameter int KEY_W = 7,
    parameter int WIN_W = 3,
    parameter int MSK_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic [WIN_W-1:0] win_cfg,
    input  logic [MSK_W-1:0] msk_cfg,
    input  logic             press_vld,
    input  logic [KEY_W-1:0] press_key,
    input  logic [KEY_W-1:0] key1,
    input  logic [KEY_W-1:0] key2,
    input  logic             win_exp,
    input  logic             msk_exp,
    input  logic             msk_run,
    output logic             win_load,
    output logic             win_clear,
    output logic             msk_load,
    output logic             msk_clear,
    output logic             key_irq,
    output logic             lock_irq,
    output logic             locked
);

    kl_state_e state, state_n;
    logic      key_stb, unl_stb;
    logic      any_exp, hit1, hit2;

    assign any_exp = win_exp || msk_exp;
    assign hit1    = press_vld && (press_key == key1);
    assign hit2    = press_vld && (press_key == key2) && (state == ST_WAIT2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_n;
    end

    // next state and timer control
    always_comb begin
        state_n   = state;
        win_load  = 1'b0;
        win_clear = 1'b0;
        msk_load  = 1'b0;
        msk_clear = 1'b0;
        key_stb   = 1'b0;
        unl_stb   = 1'b0;
        unique case (state)
            ST_OPEN: begin
                if (lock_wr && win_cfg != '0) begin
                    state_n   = ST_ARMED;
                    win_clear = 1'b1;
                    msk_clear = 1'b1;
                end
            end
            ST_ARMED, ST_WAIT2: begin
                if (any_exp) begin
                    state_n   = ST_ARMED;
                    win_clear = 1'b1;
                    msk_clear = 1'b1;
                end else if (press_vld) begin
                    if (msk_cfg != '0 && !msk_run && !hit2) begin
                        msk_load = 1'b1;
                        key_stb  = 1'b1;
                    end
                    if (state == ST_ARMED) begin
                        if (hit1) begin
                            win_load = 1'b1;
                            state_n  = ST_WAIT2;
                        end
                    end else if (hit2) begin
                        state_n   = ST_OPEN;
                        unl_stb   = 1'b1;
                        win_clear = 1'b1;
                        msk_clear = 1'b1;
                    end else begin
                        state_n   = ST_ARMED;
                        win_clear = 1'b1;
                    end
                end
            end
            default: state_n = ST_OPEN;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_irq  <= 1'b0;
            lock_irq <= 1'b0;
            locked   <= 1'b0;
        end else begin
            key_irq  <= key_stb;
            lock_irq <= unl_stb;
            locked   <= (state_n != ST_OPEN);
        end
    end

    // R4
    unlock_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> lock_irq)
        else $error("unlock without lock interrupt");

    // R4
    irq_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_irq |-> !locked)
        else $error("lock interrupt while still locked");

    // R2
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(lock_wr && win_cfg != '0))
        else $error("locked without a valid lock request");

    // R9
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |-> $past(msk_cfg != '0))
        else $error("key interrupt with mask period zero");

    // R7
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |-> $past(!msk_run))
        else $error("key interrupt while mask timer running");

    // R10
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_irq && lock_irq))
        else $error("both interrupts at once");

endmodule

// File: rtl/keylock_seq.sv
module keylock_seq #(
    parameter int KEY_W = 7,
    parameter int WIN_W = 3,
    parameter int MSK_W = 5,
    localparam int CFG_W = WIN_W + MSK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] tmr_cfg,
    input  logic [KEY_W-1:0] unlock_key1,
    input  logic [KEY_W-1:0] unlock_key2,
    input  logic             lock_wr,
    input  logic             sec_tick,
    input  logic             press_vld,
    input  logic [KEY_W-1:0] press_key,
    output logic             key_irq,
    output logic             lock_irq,
    output logic             locked
);

    logic [WIN_W-1:0] win_cfg;
    logic [MSK_W-1:0] msk_cfg;
    logic win_load, win_clear, win_run, win_exp;
    logic msk_load, msk_clear, msk_run, msk_exp;

    assign win_cfg = tmr_cfg[WIN_W-1:0];
    assign msk_cfg = tmr_cfg[CFG_W-1:WIN_W];

    kl_sec_timer #(.W(WIN_W)) u_win_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (win_cfg),
        .clear    (win_clear),
        .tick     (sec_tick),
        .running  (win_run),
        .expire   (win_exp)
    );

    kl_sec_timer #(.W(MSK_W)) u_msk_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (msk_load),
        .load_val (msk_cfg),
        .clear    (msk_clear),
        .tick     (sec_tick),
        .running  (msk_run),
        .expire   (msk_exp)
    );

    kl_seq_fsm #(.KEY_W(KEY_W), .WIN_W(WIN_W), .MSK_W(MSK_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_wr   (lock_wr),
        .win_cfg   (win_cfg),
        .msk_cfg   (msk_cfg),
        .press_vld (press_vld),
        .press_key (press_key),
        .key1      (unlock_key1),
        .key2      (unlock_key2),
        .win_exp   (win_exp),
        .msk_exp   (msk_exp),
        .msk_run   (msk_run),
        .win_load  (win_load),
        .win_clear (win_clear),
        .msk_load  (msk_load),
        .msk_clear (msk_clear),
        .key_irq   (key_irq),
        .lock_irq  (lock_irq),
        .locked    (locked)
    );

    // R5
    win_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !win_run)
        else $error("window timer running while unlocked");

endmodule

// File: tb/tb_keylock_seq.sv
module tb_keylock_seq;

    localparam time CLK_P = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tmr_cfg = {5'd3, 3'd2};
    logic [6:0] unlock_key1 = 7'd5;
    logic [6:0] unlock_key2 = 7'd9;
    logic       lock_wr = 1'b0;
    logic       sec_tick = 1'b0;
    logic       press_vld = 1'b0;
    logic [6:0] press_key = '0;
    logic       key_irq, lock_irq, locked;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_P/2) clk = ~clk;

    keylock_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tmr_cfg     (tmr_cfg),
        .unlock_key1 (unlock_key1),
        .unlock_key2 (unlock_key2),
        .lock_wr     (lock_wr),
        .sec_tick    (sec_tick),
        .press_vld   (press_vld),
        .press_key   (press_key),
        .key_irq     (key_irq),
        .lock_irq    (lock_irq),
        .locked      (locked)
    );

    // vector: [12] lock_wr [11] press_vld [10:4] key [3] tick [2] exp key_irq [1] exp lock_irq [0] exp locked
    // config during the table: window 2 s, mask 3 s, key1 = 5, key2 = 9
    localparam int NV = 29;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b0, 7'd0, 1'b0, 3'b000},  //  0 R1 idle
        {1'b0, 1'b1, 7'd5, 1'b0, 3'b000},  //  1 R3 press while open
        {1'b1, 1'b0, 7'd0, 1'b0, 3'b001},  //  2 R2 lock
        {1'b1, 1'b0, 7'd0, 1'b0, 3'b001},  //  3 R3 relock ignored
        {1'b0, 1'b1, 7'd7, 1'b0, 3'b101},  //  4 R7 first press
        {1'b0, 1'b0, 7'd0, 1'b0, 3'b001},  //  5 R7 pulse ends
        {1'b0, 1'b1, 7'd5, 1'b0, 3'b001},  //  6 R7 key1, masked
        {1'b0, 1'b0, 7'd0, 1'b1, 3'b001},  //  7 R5 tick in window
        {1'b0, 1'b1, 7'd9, 1'b0, 3'b010},  //  8 R4 unlock
        {1'b0, 1'b0, 7'd0, 1'b0, 3'b000},  //  9 R4 pulse ends
        {1'b1, 1'b0, 7'd0, 1'b0, 3'b001},  // 10 R2 lock again
        {1'b0, 1'b1, 7'd5, 1'b0, 3'b101},  // 11 R7 key1 first press
        {1'b0, 1'b0, 7'd0, 1'b1, 3'b001},  // 12 R5 tick
        {1'b0, 1'b0, 7'd0, 1'b1, 3'b001},  // 13 R5 window expires
        {1'b0, 1'b1, 7'd9, 1'b0, 3'b101},  // 14 R11 re-armed, no unlock
        {1'b0, 1'b1, 7'd5, 1'b0, 3'b001},  // 15 R6 key1
        {1'b0, 1'b1, 7'd3, 1'b0, 3'b001},  // 16 R6 wrong key
        {1'b0, 1'b1, 7'd9, 1'b0, 3'b001},  // 17 R6 key2 now useless
        {1'b0, 1'b0, 7'd0, 1'b1, 3'b001},  // 18 R8 tick
        {1'b0, 1'b0, 7'd0, 1'b1, 3'b001},  // 19 R8 tick
        {1'b0, 1'b0, 7'd0, 1'b1, 3'b001},  // 20 R8 mask expires
        {1'b0, 1'b1, 7'd9, 1'b0, 3'b101},  // 21 R8 key_irq again
        {1'b0, 1'b1, 7'd5, 1'b0, 3'b001},  // 22 R10 key1
        {1'b0, 1'b0, 7'd0, 1'b1, 3'b001},  // 23 R10 tick
        {1'b0, 1'b1, 7'd9, 1'b1, 3'b001},  // 24 R10 expiry beats key2
        {1'b0, 1'b1, 7'd9, 1'b0, 3'b101},  // 25 R11 re-armed
        {1'b0, 1'b1, 7'd5, 1'b0, 3'b001},  // 26 R4 key1
        {1'b0, 1'b1, 7'd9, 1'b0, 3'b010},  // 27 R4 unlock
        {1'b0, 1'b1, 7'd5, 1'b0, 3'b000}   // 28 R3 press while open
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic l, input logic p, input logic [6:0] k, input logic t);
        @(negedge clk);
        lock_wr   = l;
        press_vld = p;
        press_key = k;
        sec_tick  = t;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        lock_wr   = 1'b0;
        press_vld = 1'b0;
        sec_tick  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "locked in reset", locked, 1'b0);
        chk("R1", "key_irq in reset", key_irq, 1'b0);
        chk("R1", "lock_irq in reset", lock_irq, 1'b0);
        do_reset();

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12], VEC[i][11], VEC[i][10:4], VEC[i][3]);
            chk($sformatf("R-vec%0d", i), "key_irq", key_irq, VEC[i][2]);
            chk($sformatf("R-vec%0d", i), "lock_irq", lock_irq, VEC[i][1]);
            chk($sformatf("R-vec%0d", i), "locked", locked, VEC[i][0]);
        end

        // R9: mask period zero, window 1
        tmr_cfg = {5'd0, 3'd1};
        do_reset();
        step(1'b1, 1'b0, 7'd0, 1'b0);
        chk("R9", "locked", locked, 1'b1);
        step(1'b0, 1'b1, 7'd4, 1'b0);
        chk("R9", "no key_irq", key_irq, 1'b0);
        step(1'b0, 1'b1, 7'd5, 1'b0);
        chk("R9", "no key_irq on key1", key_irq, 1'b0);
        step(1'b0, 1'b1, 7'd9, 1'b0);
        chk("R9", "lock_irq", lock_irq, 1'b1);
        chk("R9", "key_irq quiet", key_irq, 1'b0);
        chk("R9", "unlocked", locked, 1'b0);

        // R2: window zero blocks locking
        tmr_cfg = {5'd2, 3'd0};
        step(1'b1, 1'b0, 7'd0, 1'b0);
        chk("R2", "window zero no lock", locked, 1'b0);
        step(1'b0, 1'b0, 7'd0, 1'b0);
        chk("R2", "still unlocked", locked, 1'b0);

        // R10: mask expiry with a press in the same cycle
        tmr_cfg = {5'd1, 3'd3};
        step(1'b1, 1'b0, 7'd0, 1'b0);
        step(1'b0, 1'b1, 7'd4, 1'b0);
        chk("R7", "first press", key_irq, 1'b1);
        step(1'b0, 1'b1, 7'd6, 1'b1);
        chk("R10", "press dropped on expiry", key_irq, 1'b0);
        chk("R10", "still locked", locked, 1'b1);
        step(1'b0, 1'b1, 7'd6, 1'b0);
        chk("R8", "re-armed after mask expiry", key_irq, 1'b1);

        // R1: asynchronous reset while locked
        @(negedge clk);
        press_vld = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1", "reset clears locked", locked, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 7'd0, 1'b0);
        chk("R1", "open after reset", locked, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule